// File: doc/BRIEF.md
# PWM Input Period and High-Time Meter

This block measures an external pulse-width-modulated signal in units of a local timer. A free-running up-counter is advanced through a programmable clock divider and wraps to zero after a programmed top value. One of two input pins is chosen and passed through a two-flop synchroniser. One capture unit takes the counter value on rising edges and the other on falling edges.

A start pulse restarts the timer, clears the event dividers and the results, and arms a measurement. The first counted rising edge fixes the reference time t0. The second counted rising edge fixes t2. The falling-edge value held at that moment is t1. From these the block forms the period and the high time in counter ticks. Both differences are wrap-aware, and the high time is corrected for a stale or late falling capture. An event divider lets each unit capture only on every 2^k-th qualifying edge, so fast signals can be measured over several cycles.

The results come with a one-cycle valid pulse and then hold until the next start. If the second counted rising edge does not arrive within a programmed number of clock cycles, a one-cycle timeout pulse is raised and the measurement is dropped.

Top module: `pwm_capture`

## Requirements
- R1: After reset, period_o and duty_o are 0, and valid_o and timeout_o are low.
- R2: The clock edge that samples start sets the timer to 0. After that the timer advances by one every psc+1 clocks and goes from cnt_max back to 0. If n clock edges have followed the start edge, the timer reads (n / (psc+1)) mod (cnt_max+1).
- R3: in_sel=0 measures pwm_in[0] and in_sel=1 measures pwm_in[1]; activity on the other pin has no effect on the results. A level change first sampled at clock edge a captures the timer value held after edge a+1.
- R4: The span between the two counted rising captures t0 and t2 is t2-t0 when t2 >= t0, and cnt_max-t0+t2 otherwise. With evdiv=0 the reported period is this span.
- R5: The raw high time is formed from t0 and the falling value t1 with the same wrap rule as R4. If it exceeds the span, the span is subtracted from it. With evdiv=0 this value is reported as duty_o.
- R6: With evdiv=k (0..3) each capture unit captures on the first qualifying edge after start and then on every 2^k-th one. The reported period is the span shifted right by k.
- R7: With k>0, if the high time after R5 is at least span>>k, it is replaced by (span>>k) - (span - high time).
- R8: Let a be the clock edge that first samples the second counted rise. valid_o is high for exactly one cycle, after edge a+2. The results hold until the next start, and the start edge clears them to 0.
- R9: If no result has been produced, timeout_o pulses for one cycle after clock edge timeout_lim+1 counted from the start edge. The measurement is then abandoned and later edges produce no valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 2 | Two candidate PWM input pins |
| in_sel | input | 1 | Selects which pin is measured |
| start | input | 1 | Restarts the timer and arms a measurement |
| psc | input | PSC_W | Timer clock divider minus one |
| cnt_max | input | CNT_W | Timer top value before wrapping to 0 |
| evdiv | input | DIV_W | Log2 of the capture event divider |
| timeout_lim | input | TMO_W | Cycle budget for a measurement |
| period_o | output | CNT_W | Measured period in ticks |
| duty_o | output | CNT_W | Measured high time in ticks |
| valid_o | output | 1 | One-cycle result strobe |
| timeout_o | output | 1 | One-cycle timeout strobe |

## Verification
The bench goes after small top values, where the timer wraps one or more times inside a span. A design that used the plain difference there would report huge periods, and one that got the off-by-one wrap rule wrong would be one tick out.

It starts measurements at both input levels with the event divider active. A design that drops the R7 correction would report nearly the whole multi-cycle span as the high time when the input was high at start.

It also toggles the unselected pin, runs with a non-zero timer divider, and checks the exact cycle of the valid strobe. It checks the timeout edge exactly as well, so a wrong synchroniser depth, a counter that ignores the divider, or a timeout one cycle off each changes a compared value.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;

    typedef enum logic [1:0] {
        MS_IDLE   = 2'd0,
        MS_FIRST  = 2'd1,
        MS_SECOND = 2'd2
    } meas_st_e;

    localparam int NUM_UNITS = 2;

endpackage

// File: rtl/pwmcap_timebase.sv
module pwmcap_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] cnt_max,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [PSC_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (restart) begin
            tb_d.pre = '0;
            tb_d.cnt = '0;
        end else if (tb_q.pre >= psc) begin
            tb_d.pre = '0;
            tb_d.cnt = (tb_q.cnt >= cnt_max) ? '0 : tb_q.cnt + 1'b1;
        end else begin
            tb_d.pre = tb_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign cnt_o = tb_q.cnt;

    // R2: between divider ticks the timer does not move
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && tb_q.pre < psc) |=> $stable(tb_q.cnt));

    // R2: a restart always leaves the timer at zero
    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_o == '0));

endmodule

// File: rtl/pwmcap_edges.sv
module pwmcap_edges (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pins,
    input  logic       sel,
    output logic       rise_o,
    output logic       fall_o
);

    typedef struct packed {
        logic [1:0] s1;
        logic [1:0] s2;
        logic       last;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  lvl;

    assign lvl = sy_q.s2[sel];

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pins;
        sy_d.s2   = sy_q.s1;
        sy_d.last = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rise_o = lvl & ~sy_q.last;
    assign fall_o = ~lvl & sy_q.last;

    // R3: two rises cannot be seen back to back on an unchanged selection
    assert_no_double_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> (!rise_o || sel != $past(sel)));

endmodule

// File: rtl/pwmcap_evdiv.sv
module pwmcap_evdiv #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             evt,
    input  logic [DIV_W-1:0] k,
    output logic             hit
);

    localparam int EV_W = (1 << DIV_W) - 1;

    logic [EV_W-1:0] ev_d, ev_q, mask;

    assign mask = ~({EV_W{1'b1}} << k);
    assign hit  = en & evt & ~clr & ((ev_q & mask) == '0);

    always_comb begin
        ev_d = ev_q;
        if (clr)           ev_d = '0;
        else if (en & evt) ev_d = (ev_q + 1'b1) & mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    // R6: with division active a capture is never followed by another at once
    assert_div_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && k != '0) |=> (!hit || k != $past(k)));

endmodule

// File: rtl/pwm_capture.sv
module pwm_capture
    import pwmcap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8,
    parameter int TMO_W = 20,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pwm_in,
    input  logic             in_sel,
    input  logic             start,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] cnt_max,
    input  logic [DIV_W-1:0] evdiv,
    input  logic [TMO_W-1:0] timeout_lim,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] duty_o,
    output logic             valid_o,
    output logic             timeout_o
);

    typedef struct packed {
        meas_st_e         st;
        logic [TMO_W-1:0] tmo;
        logic [CNT_W-1:0] t0;
        logic [CNT_W-1:0] fall;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] dty;
        logic             valid;
        logic             tout;
    } cap_t;

    cap_t cp_d, cp_q;

    logic [CNT_W-1:0]     cnt;
    logic                 ev_rise, ev_fall;
    logic [NUM_UNITS-1:0] evts, hits;
    logic                 armed;
    logic [CNT_W-1:0]     span, hi_raw, hi_fix, span_k, hi_out;

    function automatic logic [CNT_W-1:0] wrap_gap(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b,
                                                 input logic [CNT_W-1:0] top);
        return (b >= a) ? (b - a) : (top - a + b);
    endfunction

    pwmcap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .psc(psc), .cnt_max(cnt_max), .cnt_o(cnt)
    );

    pwmcap_edges u_edges (
        .clk(clk), .rst_n(rst_n), .pins(pwm_in), .sel(in_sel),
        .rise_o(ev_rise), .fall_o(ev_fall)
    );

    assign armed   = (cp_q.st != MS_IDLE);
    assign evts[0] = ev_rise;
    assign evts[1] = ev_fall;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        pwmcap_evdiv #(.DIV_W(DIV_W)) u_div (
            .clk(clk), .rst_n(rst_n), .clr(start), .en(armed),
            .evt(evts[u]), .k(evdiv), .hit(hits[u])
        );
    end

    // result arithmetic, evaluated against the live timer value
    always_comb begin
        span   = wrap_gap(cp_q.t0, cnt, cnt_max);
        hi_raw = wrap_gap(cp_q.t0, cp_q.fall, cnt_max);
        hi_fix = (hi_raw > span) ? (hi_raw - span) : hi_raw;
        span_k = span >> evdiv;
        hi_out = ((evdiv != '0) && (hi_fix >= span_k)) ? (span_k - (span - hi_fix)) : hi_fix;
    end

    always_comb begin
        cp_d       = cp_q;
        cp_d.valid = 1'b0;
        cp_d.tout  = 1'b0;
        if (start) begin
            cp_d.st   = MS_FIRST;
            cp_d.tmo  = '0;
            cp_d.t0   = '0;
            cp_d.fall = '0;
            cp_d.per  = '0;
            cp_d.dty  = '0;
        end else if (armed) begin
            cp_d.tmo = cp_q.tmo + 1'b1;
            if (hits[1]) cp_d.fall = cnt;
            if (hits[0] && cp_q.st == MS_FIRST) begin
                cp_d.t0 = cnt;
                cp_d.st = MS_SECOND;
            end else if (hits[0]) begin
                cp_d.per   = span_k;
                cp_d.dty   = hi_out;
                cp_d.valid = 1'b1;
                cp_d.st    = MS_IDLE;
            end else if (cp_q.tmo >= timeout_lim) begin
                cp_d.tout = 1'b1;
                cp_d.st   = MS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cp_q <= '{st: MS_IDLE, default: '0};
        else        cp_q <= cp_d;
    end

    assign period_o  = cp_q.per;
    assign duty_o    = cp_q.dty;
    assign valid_o   = cp_q.valid;
    assign timeout_o = cp_q.tout;

    // R8: the result strobe lasts a single cycle
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: results only move on a start or together with the strobe
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (($stable(period_o) && $stable(duty_o)) || valid_o));

    // R9: timeout is a single-cycle pulse and never coincides with a result
    assert_tout_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);
    assert_tout_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_o && valid_o));

endmodule

// File: tb/pwm_capture_test.sv
module pwm_capture_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  pwm_in;
    logic        in_sel;
    logic        start;
    logic [7:0]  psc;
    logic [15:0] cnt_max;
    logic [1:0]  evdiv;
    logic [19:0] timeout_lim;
    logic [15:0] period_o, duty_o;
    logic        valid_o, timeout_o;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwm_capture uut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .in_sel(in_sel),
        .start(start), .psc(psc), .cnt_max(cnt_max), .evdiv(evdiv),
        .timeout_lim(timeout_lim), .period_o(period_o), .duty_o(duty_o),
        .valid_o(valid_o), .timeout_o(timeout_o)
    );

    always @(negedge clk) if (valid_o) vcount++;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic int timer_at(input int j, input int p, input int mx);
        return (j / (p + 1)) % (mx + 1);
    endfunction

    function automatic logic [15:0] gap(input logic [15:0] a, input logic [15:0] b, input logic [15:0] mx);
        return (b >= a) ? (b - a) : (mx - a + b);
    endfunction

    // one measurement; lit_p / lit_d < 0 skips the literal comparison
    task automatic run_meas(input int p, input int mx, input int k, input bit s,
                            input int hi, input int lo, input bit lvl0, input int dly,
                            input int oth, input int lit_p, input int lit_d, input string tag);
        logic [15:0] t0, t1, t2, bval, span, hd, pk, ep, ed, keep_p, keep_d;
        int nA, rc, fc, expm, ph, msk;
        bit lvl;
        string plab, dlab;
        t0 = 0; t1 = 0; t2 = 0; bval = 0; ep = 0; ed = 0;
        nA = 0; rc = 0; fc = 0; expm = -1;
        msk = (1 << k) - 1;
        plab = (p > 0) ? "R2" : ((k == 0) ? "R4" : "R6");
        dlab = (k == 0) ? "R5" : "R7";
        @(negedge clk);
        psc = 8'(p); cnt_max = 16'(mx); evdiv = 2'(k); in_sel = s;
        timeout_lim = 20'd100000;
        pwm_in[s] = lvl0; pwm_in[!s] = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R8", {tag, " start clears period"}, period_o, 0);
        lvl = lvl0;
        ph = dly;
        for (int j = 1; j < 4000; j++) begin
            if (expm >= 0 && j - 1 == expm) begin
                chk("R8", {tag, " valid strobe edge"}, valid_o, 1);
                chk(plab, {tag, " period"}, period_o, ep);
                chk(dlab, {tag, " duty"}, duty_o, ed);
                if (lit_p >= 0) chk(plab, {tag, " period literal"}, period_o, lit_p);
                if (lit_d >= 0) chk(dlab, {tag, " duty literal"}, duty_o, lit_d);
            end else if (expm >= 0 && j - 1 == expm + 1) begin
                chk("R8", {tag, " valid drops"}, valid_o, 0);
                break;
            end else if (valid_o) begin
                chk("R8", {tag, " early valid"}, valid_o, 0);
            end
            ph--;
            if (ph == 0) begin
                lvl = ~lvl;
                ph = lvl ? hi : lo;
                pwm_in[s] = lvl;
                if (lvl) begin
                    if ((rc & msk) == 0) begin
                        if (nA == 0) begin
                            t0 = 16'(timer_at(j + 1, p, mx));
                            nA = 1;
                        end else if (nA == 1) begin
                            t2 = 16'(timer_at(j + 1, p, mx));
                            t1 = bval;
                            nA = 2;
                            expm = j + 2;
                            span = gap(t0, t2, 16'(mx));
                            hd = gap(t0, t1, 16'(mx));
                            if (hd > span) hd = hd - span;
                            pk = span >> k;
                            if (k != 0 && hd >= pk) hd = pk - (span - hd);
                            ep = pk;
                            ed = hd;
                        end
                    end
                    rc++;
                end else begin
                    if ((fc & msk) == 0 && nA < 2) bval = 16'(timer_at(j + 1, p, mx));
                    fc++;
                end
            end
            if (oth > 0 && (j % oth) == 0) pwm_in[!s] = ~pwm_in[!s];
            @(posedge clk);
            @(negedge clk);
        end
        if (expm < 0) chk("R8", {tag, " no result"}, 0, 1);
        keep_p = period_o;
        keep_d = duty_o;
        pwm_in[s] = ~pwm_in[s];
        repeat (6) @(negedge clk);
        chk("R8", {tag, " period held"}, period_o, keep_p);
        chk("R8", {tag, " duty held"}, duty_o, keep_d);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        wrap_up();
    end

    initial begin
        int vbefore;
        void'($urandom(32'd4321));
        rst_n = 1'b0; pwm_in = 2'b00; in_sel = 1'b0; start = 1'b0;
        psc = 8'd0; cnt_max = 16'd1000; evdiv = 2'd0; timeout_lim = 20'd100000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "period after reset", period_o, 0);
        chk("R1", "duty after reset", duty_o, 0);
        chk("R1", "valid after reset", valid_o, 0);
        chk("R1", "timeout after reset", timeout_o, 0);

        // directed corner cases
        run_meas(0, 1000, 0, 1'b0, 7, 13, 1'b0, 4, 0, 20, 7, "R4 basic");
        run_meas(0, 20, 0, 1'b0, 10, 20, 1'b0, 5, 0, -1, -1, "R4 R5 wrap");
        run_meas(0, 20, 0, 1'b0, 12, 18, 1'b1, 3, 0, -1, -1, "R5 multiwrap");
        run_meas(2, 1000, 0, 1'b0, 9, 21, 1'b0, 4, 0, 10, -1, "R2 divider");
        run_meas(0, 5000, 2, 1'b0, 6, 4, 1'b1, 3, 0, 10, 6, "R7 start high");
        run_meas(0, 5000, 2, 1'b0, 6, 4, 1'b0, 3, 0, 10, 6, "R6 start low");
        run_meas(0, 5000, 3, 1'b0, 3, 5, 1'b0, 3, 0, 8, 3, "R6 div8");
        run_meas(0, 1000, 0, 1'b1, 5, 8, 1'b0, 4, 3, 13, 5, "R3 sel1");
        run_meas(0, 1000, 0, 1'b0, 5, 8, 1'b0, 4, 2, 13, 5, "R3 sel0");

        // R9 timeout
        @(negedge clk);
        pwm_in = 2'b00; in_sel = 1'b0; timeout_lim = 20'd50; evdiv = 2'd0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        vbefore = vcount;
        repeat (50) @(negedge clk);
        chk("R9", "timeout before limit", timeout_o, 0);
        @(negedge clk);
        chk("R9", "timeout at limit", timeout_o, 1);
        @(negedge clk);
        chk("R9", "timeout pulse ends", timeout_o, 0);
        for (int i = 0; i < 8; i++) begin
            pwm_in[0] = ~pwm_in[0];
            repeat (5) @(negedge clk);
        end
        chk("R9", "no valid after abandon", vcount, vbefore);

        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            run_meas(int'($urandom_range(0, 3)), int'($urandom_range(40, 600)),
                     int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(2, 30)), int'($urandom_range(2, 30)),
                     1'($urandom_range(0, 1)), int'($urandom_range(3, 10)),
                     int'($urandom_range(0, 17)), -1, -1, "rand");
        end
        wrap_up();
    end

endmodule